// File: doc/BRIEF.md
# SPI Register Command Decoder

This block sits behind a byte-level SPI slave. It reads the stream of received bytes as a small command protocol. The first byte of every transaction is a command. That command selects one of three things: returning an 8-bit status value, returning one of sixteen 32-bit registers, or loading one of those registers. Each time a byte completes, the block registers the byte that the slave should shift out during the next exchange.

Registers 0 to 3 are held inside the block, can be read and written, and are driven out to user logic. Registers 4 to 15 belong to user logic: the block only reads them from its inputs, and writes to them are discarded. Dropping chip select abandons whatever transaction is under way.

Top module: `spi_regcmd`

## Requirements
- R1: During and after reset, `tx_byte` is 0x00 and every writable register is zero.
- R2: Command 0x00 returns status. The byte shifted out in the exchange after the command is the `status_in` value captured when the command byte arrived. The byte after that is decoded as a new command.
- R3: Command 0x80 + n (n = 0..15 in bits 3:0) returns register n in the four exchanges after the command, bits 31:24 first and bits 7:0 last. The byte after those four is decoded as a new command.
- R4: The value returned by a read is captured when the command byte is decoded. Changes to the register inputs during the four data bytes do not alter the bytes returned.
- R5: Command 0xC0 + n with n < 4 loads register n from the next four bytes, most significant first. The new value appears on `rw_regs` in the clock cycle after the fourth data byte. After three data bytes the register is still unchanged.
- R6: Command 0xC0 + n with n >= 4 consumes four data bytes and leaves every writable register unchanged. Reads of registers 4..15 keep reflecting `ro_regs`.
- R7: While `cs_active` is low the decoder returns to waiting for a command and `tx_byte` becomes 0x00. A write cut short this way leaves its register unchanged.
- R8: A command byte that is neither 0x00, 0x80..0x8F nor 0xC0..0xCF is discarded. The byte shifted out after it is 0x00, and the next byte is decoded as a command.
- R9: The byte shifted out while a command byte is being received is 0x00 when idle. So is every byte shifted out during the data bytes of a write.
- R10: Commands follow each other with no gap: a read that immediately follows a write returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | Chip select asserted (active high, already synchronised) |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| status_in | input | 8 | Status value returned by command 0x00 |
| ro_regs | input | 384 | Registers 4..15; register k sits at bits (k-4)*32 +: 32 |
| tx_byte | output | 8 | Byte to shift out in the next exchange |
| rw_regs | output | 128 | Registers 0..3; register k sits at bits k*32 +: 32 |

## Verification
The bench writes each writable register with a distinct value and reads all sixteen registers back. This shows that index decoding, byte order and the split between the writable and read-only ranges are all correct. A write to every read-only index is followed by a full compare of the writable outputs, which separates a discarded write from an aliased one. Every one of the 256 command values that is not defined is tried, and each is followed by a status command. This shows both the zero reply and that the decoder has gone back to expecting a command. Further sequences change register inputs in the middle of a read, stop a write after three bytes, drop chip select in the middle of a transaction, and issue commands back to back. These cover the snapshot, the commit timing and the abort rules.

// File: rtl/spi_regcmd_pkg.sv
`timescale 1ns/1ps
package spi_regcmd_pkg;

  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int NUM_REGS = 1 << IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STAT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } cmd_state_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STATUS = 2'd1,
    CMD_READ   = 2'd2,
    CMD_WRITE  = 2'd3
  } cmd_kind_e;

  // Classify a command byte; the upper nibble picks the kind
  function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
    if (b == 8'h00)           return CMD_STATUS;
    else if (b[7:4] == 4'h8)  return CMD_READ;
    else if (b[7:4] == 4'hC)  return CMD_WRITE;
    else                      return CMD_NONE;
  endfunction

  // Register index carried in the low nibble of a command
  function automatic logic [IDX_W-1:0] cmd_index(input logic [BYTE_W-1:0] b);
    return b[IDX_W-1:0];
  endfunction

endpackage

// File: rtl/spi_regcmd_fsm.sv
`timescale 1ns/1ps
module spi_regcmd_fsm
  import spi_regcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output cmd_state_e        st_q,
  output logic              rx_go,
  output logic              ev_cmd_status,
  output logic              ev_cmd_read,
  output logic              ev_cmd_bad,
  output logic              ev_read_step,
  output logic              ev_read_last,
  output logic              ev_write_byte,
  output logic              ev_write_done,
  output logic [IDX_W-1:0]  idx_q
);

  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);

  cmd_state_e       st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cmd_kind_e        kind;
  logic             in_idle, last_slot, ev_cmd_write;

  assign rx_go     = rx_valid & cs_active;
  assign kind      = classify(rx_byte);
  assign in_idle   = (st_q == ST_IDLE);
  assign last_slot = (cnt_q == CNT_W'(NBYTES - 1));

  assign ev_cmd_status = rx_go & in_idle & (kind == CMD_STATUS);
  assign ev_cmd_read   = rx_go & in_idle & (kind == CMD_READ);
  assign ev_cmd_write  = rx_go & in_idle & (kind == CMD_WRITE);
  assign ev_cmd_bad    = rx_go & in_idle & (kind == CMD_NONE);
  assign ev_read_step  = rx_go & (st_q == ST_READ)  & ~last_slot;
  assign ev_read_last  = rx_go & (st_q == ST_READ)  &  last_slot;
  assign ev_write_byte = rx_go & (st_q == ST_WRITE) & ~last_slot;
  assign ev_write_done = rx_go & (st_q == ST_WRITE) &  last_slot;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (rx_go) begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          unique case (kind)
            CMD_STATUS: st_d = ST_STAT;
            CMD_READ:   st_d = ST_READ;
            CMD_WRITE:  st_d = ST_WRITE;
            default:    st_d = ST_IDLE;
          endcase
        end
        ST_STAT: st_d = ST_IDLE;
        default: begin
          if (last_slot) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!cs_active) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ev_cmd_read | ev_cmd_write) idx_q <= cmd_index(rx_byte);
    end
  end

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> st_q == ST_IDLE);

  // R3
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_last |=> st_q == ST_IDLE);

endmodule

// File: rtl/spi_regcmd_bank.sv
`timescale 1ns/1ps
module spi_regcmd_bank
  import spi_regcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RW = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [(NUM_REGS-NUM_RW)*DATA_W-1:0]  ro_flat,
  input  logic                                 wr_byte,
  input  logic                                 wr_commit,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  logic [BYTE_W-1:0]                    rx_byte,
  input  logic [IDX_W-1:0]                     rd_idx,
  output logic [NUM_RW*DATA_W-1:0]             rw_flat,
  output logic [DATA_W-1:0]                    rd_data
);

  localparam int ASM_W = DATA_W - BYTE_W;

  logic [ASM_W-1:0]  asm_q;
  logic [DATA_W-1:0] all_regs [NUM_REGS];
  logic [DATA_W-1:0] wr_word;

  assign wr_word = {asm_q, rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       asm_q <= '0;
    else if (wr_byte) asm_q <= ASM_W'({asm_q, rx_byte});
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi < NUM_RW) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     q <= '0;
        else if (wr_commit && wr_idx == IDX_W'(gi))     q <= wr_word;
      end
      assign all_regs[gi]                   = q;
      assign rw_flat[gi*DATA_W +: DATA_W]   = q;
    end else begin : g_ro
      assign all_regs[gi] = ro_flat[(gi-NUM_RW)*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = all_regs[i];
  end

  // R5
  rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(rw_flat));

  // R6
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_idx >= IDX_W'(NUM_RW)) |=> $stable(rw_flat));

endmodule

// File: rtl/spi_regcmd_txpath.sv
`timescale 1ns/1ps
module spi_regcmd_txpath
  import spi_regcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_go,
  input  logic              ev_cmd_status,
  input  logic              ev_cmd_read,
  input  logic              ev_cmd_bad,
  input  logic              ev_read_step,
  input  logic              ev_write_byte,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [BYTE_W-1:0] tx_byte
);

  localparam int SNAP_W = DATA_W - BYTE_W;

  logic [SNAP_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      snap_q  <= '0;
    end else if (!cs_active) begin
      tx_byte <= '0;
    end else if (ev_cmd_status) begin
      tx_byte <= status_in;
    end else if (ev_cmd_read) begin
      {tx_byte, snap_q} <= rd_data;
    end else if (ev_read_step) begin
      {tx_byte, snap_q} <= {snap_q, {BYTE_W{1'b0}}};
    end else if (rx_go) begin
      tx_byte <= '0;
    end
  end

  // R8
  bad_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_bad |=> tx_byte == '0);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_byte |=> tx_byte == '0);

  // R2
  status_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_status |=> tx_byte == $past(status_in));

endmodule

// File: rtl/spi_regcmd.sv
`timescale 1ns/1ps
module spi_regcmd
  import spi_regcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RW = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cs_active,
  input  logic                                rx_valid,
  input  logic [7:0]                          rx_byte,
  input  logic [7:0]                          status_in,
  input  logic [(16-NUM_RW)*DATA_W-1:0]       ro_regs,
  output logic [7:0]                          tx_byte,
  output logic [NUM_RW*DATA_W-1:0]            rw_regs
);

  cmd_state_e        st_q;
  logic              rx_go, ev_cmd_status, ev_cmd_read, ev_cmd_bad;
  logic              ev_read_step, ev_read_last, ev_write_byte, ev_write_done;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] rd_data;

  spi_regcmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk, .rst_n, .cs_active, .rx_valid, .rx_byte,
    .st_q, .rx_go, .ev_cmd_status, .ev_cmd_read, .ev_cmd_bad,
    .ev_read_step, .ev_read_last, .ev_write_byte, .ev_write_done, .idx_q
  );

  spi_regcmd_bank #(.DATA_W(DATA_W), .NUM_RW(NUM_RW)) u_bank (
    .clk, .rst_n,
    .ro_flat   (ro_regs),
    .wr_byte   (ev_write_byte),
    .wr_commit (ev_write_done),
    .wr_idx    (idx_q),
    .rx_byte,
    .rd_idx    (cmd_index(rx_byte)),
    .rw_flat   (rw_regs),
    .rd_data
  );

  spi_regcmd_txpath #(.DATA_W(DATA_W)) u_tx (
    .clk, .rst_n, .cs_active, .rx_go,
    .ev_cmd_status, .ev_cmd_read, .ev_cmd_bad, .ev_read_step, .ev_write_byte,
    .status_in, .rd_data, .tx_byte
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_byte == '0 && rw_regs == '0));

endmodule

// File: tb/sim_spi_regcmd.sv
`timescale 1ns/1ps
module sim_spi_regcmd;

  logic         clk = 1'b0;
  logic         rst_n, cs_active, rx_valid;
  logic [7:0]   rx_byte, status_in;
  logic [383:0] ro_regs;
  logic [7:0]   tx_byte;
  logic [127:0] rw_regs;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_rw [4];

  always #2.5 clk = ~clk;

  spi_regcmd u0 (
    .clk, .rst_n, .cs_active, .rx_valid, .rx_byte,
    .status_in, .ro_regs, .tx_byte, .rw_regs
  );

  function automatic logic [31:0] ro_val(input int k);
    return (32'(k) * 32'h0103_0507) ^ 32'hA55A_3CC3;
  endfunction

  function automatic logic [127:0] rw_packed();
    return {exp_rw[3], exp_rw[2], exp_rw[1], exp_rw[0]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one byte exchange: r is what the slave shifts out during it
  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    r        = tx_byte;
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd_reg(input int k, output logic [31:0] v);
    logic [7:0] r;
    xfer(8'h80 | 8'(k), r);
    v = '0;
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      v = {v[23:0], r};
    end
  endtask

  task automatic wr_reg(input int k, input logic [31:0] v);
    logic [7:0] r;
    xfer(8'hC0 | 8'(k), r);
    for (int i = 0; i < 4; i++) begin
      xfer(v[31-8*i -: 8], r);
      chk("R9 write data reply", 128'(r), 128'h0);
    end
    if (k < 4) exp_rw[k] = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] v, old;
    rst_n = 1'b0; cs_active = 1'b0; rx_valid = 1'b0;
    rx_byte = '0; status_in = '0;
    for (int k = 4; k < 16; k++) ro_regs[(k-4)*32 +: 32] = ro_val(k);
    for (int k = 0; k < 4; k++) exp_rw[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 tx reset", 128'(tx_byte), 128'h0);
    chk("R1 regs reset", rw_regs, 128'h0);
    rst_n = 1'b1; cs_active = 1'b1;
    @(negedge clk);

    // R2 status sweep, R9 idle reply
    for (int s = 0; s < 256; s += 37) begin
      status_in = 8'(s);
      xfer(8'h00, r);
      chk("R9 idle reply", 128'(r), 128'h0);
      status_in = ~8'(s);
      xfer(8'h3C, r);
      chk("R2 status", 128'(r), 128'(s));
    end

    // R3 read all after reset
    for (int k = 0; k < 16; k++) begin
      rd_reg(k, v);
      chk("R3 read", 128'(v), 128'(k < 4 ? 32'h0 : ro_val(k)));
    end

    // R5 write all writable registers
    for (int k = 0; k < 4; k++) begin
      wr_reg(k, 32'h1234_5678 * 32'(k + 3) ^ 32'hF0E1_D2C3);
      chk("R5 commit", rw_regs, rw_packed());
    end
    for (int k = 0; k < 16; k++) begin
      rd_reg(k, v);
      chk("R3 read after write", 128'(v), 128'(k < 4 ? exp_rw[k] : ro_val(k)));
    end

    // R5 commit timing
    xfer(8'hC2, r);
    xfer(8'hAB, r); xfer(8'hCD, r); xfer(8'hEF, r);
    chk("R5 unchanged after three bytes", rw_regs, rw_packed());
    xfer(8'h01, r);
    exp_rw[2] = 32'hABCD_EF01;
    chk("R5 commit after fourth", rw_regs, rw_packed());

    // R6 writes to read-only range
    for (int k = 4; k < 16; k++) begin
      wr_reg(k, 32'hDEAD_0000 | 32'(k));
      chk("R6 regs untouched", rw_regs, rw_packed());
      rd_reg(k, v);
      chk("R6 ro still mirrors input", 128'(v), 128'(ro_val(k)));
    end

    // R4 snapshot at decode
    old = ro_val(7);
    xfer(8'h87, r);
    xfer(8'h00, r); v = {24'h0, r};
    ro_regs[3*32 +: 32] = ~old;
    for (int i = 0; i < 3; i++) begin xfer(8'h00, r); v = {v[23:0], r}; end
    chk("R4 snapshot", 128'(v), 128'(old));
    ro_regs[3*32 +: 32] = old;

    // R7 abort in a write
    xfer(8'hC1, r); xfer(8'h55, r); xfer(8'h66, r);
    cs_active = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 tx idle on abort", 128'(tx_byte), 128'h0);
    chk("R7 partial write dropped", rw_regs, rw_packed());
    cs_active = 1'b1;
    rd_reg(1, v);
    chk("R7 next byte is command", 128'(v), 128'(exp_rw[1]));
    // R7 abort in a read
    xfer(8'h85, r); xfer(8'h00, r);
    cs_active = 1'b0;
    @(negedge clk);
    cs_active = 1'b1;
    status_in = 8'h9E;
    xfer(8'h00, r); xfer(8'h00, r);
    chk("R7 status after read abort", 128'(r), 128'h9E);

    // R8 every undefined command
    for (int c = 0; c < 256; c++) begin
      if (c == 0 || (c >> 4) == 8 || (c >> 4) == 12) continue;
      status_in = 8'(c) ^ 8'h5A;
      xfer(8'(c), r);
      xfer(8'h00, r);
      chk("R8 reply after bad cmd", 128'(r), 128'h0);
      xfer(8'h11, r);
      chk("R8 next byte is command", 128'(r), 128'(8'(c) ^ 8'h5A));
    end

    // R10 back-to-back write then read
    wr_reg(3, 32'h0BAD_F00D);
    rd_reg(3, v);
    chk("R10 back-to-back", 128'(v), 128'h0BAD_F00D);
    chk("R10 outputs", rw_regs, rw_packed());

    summary();
  end

endmodule